// File: doc/BRIEF.md
# Stack Processor Primary Execution Unit

This block carries out the sixteen primary instructions of a small stack machine. Each instruction reaches it already decoded. It arrives as a 4-bit function code together with a fully assembled immediate operand, because prefix handling happens upstream. The unit holds a three-entry push-down evaluation stack (A on top, then B, then C), an instruction pointer and a workspace pointer. Every memory address it forms is relative to one of two bases: the workspace pointer or the value in A.

A single-port word memory sits behind a request/write-enable/address/data interface. Reads return data one cycle after the request. Loads therefore take two cycles, and the unit drops its ready output for the second one. All other instructions complete in the cycle they are accepted. The extended-operation function code performs no work in this unit. It raises a trap pulse that carries its index, so that a neighbouring block can act on it.

Top module: `stack_exec_unit`

## Requirements
- R1: While reset is low, A, B and C read 0, the instruction pointer reads RESET_IP (default 0), the workspace pointer reads RESET_WP (default 0x80), and ready is high with no memory request and no trap.
- R2: Function 4 (load constant) pushes the operand. C takes the old B, B takes the old A, and A takes the operand.
- R3: Function 8 adds the operand to A. Function 12 replaces A with 1 when A equals the operand and with 0 otherwise. Neither instruction touches B or C.
- R4: Every accepted instruction other than a load in progress advances the instruction pointer by 1. Function 0 instead sets it to the old pointer plus 1 plus the operand. Functions 2 and 6 (prefix codes) change nothing else.
- R5: Function 10 is taken when A is zero: the pointer becomes old pointer plus 1 plus operand, and the stack is left unchanged. When A is non-zero, the instruction falls through and pops, so A takes B and B takes C.
- R6: Function 9 pushes the return pointer (old pointer plus 1) and sets the pointer to that return value plus the operand.
- R7: Function 7 pushes the memory word at workspace plus 4×operand. Function 13 writes A to that address and then pops.
- R8: Function 3 replaces A with the word at A plus 4×operand. Function 14 writes B to A plus 4×operand, after which A holds the old C.
- R9: Function 1 pushes workspace plus 4×operand, and function 5 replaces A with A plus 4×operand. Neither issues a memory request.
- R10: Function 11 adds 4×operand to the workspace pointer.
- R11: After a load (function 3 or 7) is accepted, ready is low for exactly one cycle, and A is written with the read data at the end of that cycle.
- R12: Function 15 drives the trap output high, with the operand as its index, for the acceptance cycle only. It leaves the stack and workspace unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction present |
| instReady | output | 1 | Unit can accept an instruction this cycle |
| instFunc | input | 4 | Primary function code |
| instOperand | input | DATA_W | Assembled immediate operand |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Write enable for the request |
| memAddr | output | DATA_W | Byte address of the accessed word |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid the cycle after a read request |
| trapValid | output | 1 | Extended-operation trap pulse |
| trapIndex | output | DATA_W | Extended-operation index |
| regA | output | DATA_W | Stack top |
| regB | output | DATA_W | Stack second |
| regC | output | DATA_W | Stack third |
| iptr | output | DATA_W | Instruction pointer |
| wptr | output | DATA_W | Workspace pointer |

## Verification
A single program of twenty-two instructions runs from reset. It pushes the stack deep enough that each of the four stack motions (push, single pop, double pop, replace) becomes visible in all three registers. The conditional jump runs once with A zero and once with A non-zero, which separates the taken path from the fall-through-and-pop path. The equals test runs with a matching operand and a mismatching one. Negative operands on add, workspace adjust and jump confirm that sign wraparound works. Directed cases then check the memory contents written by both store forms, sample the ready drop during a load, confirm that pointer loads issue no request, and confirm that the trap lasts a single cycle.

// File: rtl/stack_exec_pkg.sv
package stack_exec_pkg;

  typedef enum logic [3:0] {
    FN_JUMP  = 4'h0,
    FN_LDLP  = 4'h1,
    FN_PFIX  = 4'h2,
    FN_LDNL  = 4'h3,
    FN_LDC   = 4'h4,
    FN_LDNLP = 4'h5,
    FN_NFIX  = 4'h6,
    FN_LDL   = 4'h7,
    FN_ADC   = 4'h8,
    FN_CALL  = 4'h9,
    FN_CJ    = 4'hA,
    FN_AJW   = 4'hB,
    FN_EQC   = 4'hC,
    FN_STL   = 4'hD,
    FN_STNL  = 4'hE,
    FN_OPR   = 4'hF
  } funcCode_e;

  typedef enum logic [2:0] {
    STK_HOLD,
    STK_PUSH,
    STK_POP1,
    STK_POP2,
    STK_REPLACE
  } stackOp_e;

  typedef enum logic [2:0] {
    ASEL_IMM,
    ASEL_ADDR,
    ASEL_SUM,
    ASEL_EQ,
    ASEL_MEM,
    ASEL_RET
  } aSel_e;

  typedef enum logic [1:0] {
    IP_HOLD,
    IP_STEP,
    IP_BRANCH
  } ipSel_e;

  typedef struct packed {
    stackOp_e stackOp;
    aSel_e    aSel;
    ipSel_e   ipSel;
    logic     wpAdjust;
    logic     baseWs;
  } dpCtrl_t;

endpackage

// File: rtl/stack_exec_ctrl.sv
module stack_exec_ctrl
  import stack_exec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instValid,
  input  funcCode_e instFunc,
  input  logic      aIsZero,
  output logic      instReady,
  output logic      memReq,
  output logic      memWe,
  output logic      trapValid,
  output dpCtrl_t   ctrl
);

  logic waitLoad;
  logic pushPending;
  logic fire;
  logic isLoad;

  assign instReady = !waitLoad;
  assign fire      = instValid && instReady;
  assign isLoad    = (instFunc == FN_LDL) || (instFunc == FN_LDNL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitLoad    <= 1'b0;
      pushPending <= 1'b0;
    end else begin
      waitLoad    <= fire && isLoad;
      pushPending <= fire && (instFunc == FN_LDL);
    end
  end

  always_comb begin
    ctrl.stackOp  = STK_HOLD;
    ctrl.aSel     = ASEL_IMM;
    ctrl.ipSel    = IP_HOLD;
    ctrl.wpAdjust = 1'b0;
    ctrl.baseWs   = 1'b0;
    memReq        = 1'b0;
    memWe         = 1'b0;
    trapValid     = 1'b0;
    if (waitLoad) begin
      ctrl.stackOp = pushPending ? STK_PUSH : STK_REPLACE;
      ctrl.aSel    = ASEL_MEM;
    end else if (fire) begin
      ctrl.ipSel = IP_STEP;
      unique case (instFunc)
        FN_JUMP: ctrl.ipSel = IP_BRANCH;
        FN_LDLP: begin
          ctrl.baseWs  = 1'b1;
          ctrl.stackOp = STK_PUSH;
          ctrl.aSel    = ASEL_ADDR;
        end
        FN_LDNL: memReq = 1'b1;
        FN_LDC: begin
          ctrl.stackOp = STK_PUSH;
          ctrl.aSel    = ASEL_IMM;
        end
        FN_LDNLP: begin
          ctrl.stackOp = STK_REPLACE;
          ctrl.aSel    = ASEL_ADDR;
        end
        FN_LDL: begin
          ctrl.baseWs = 1'b1;
          memReq      = 1'b1;
        end
        FN_ADC: begin
          ctrl.stackOp = STK_REPLACE;
          ctrl.aSel    = ASEL_SUM;
        end
        FN_CALL: begin
          ctrl.stackOp = STK_PUSH;
          ctrl.aSel    = ASEL_RET;
          ctrl.ipSel   = IP_BRANCH;
        end
        FN_CJ: begin
          if (aIsZero) ctrl.ipSel = IP_BRANCH;
          else         ctrl.stackOp = STK_POP1;
        end
        FN_AJW: ctrl.wpAdjust = 1'b1;
        FN_EQC: begin
          ctrl.stackOp = STK_REPLACE;
          ctrl.aSel    = ASEL_EQ;
        end
        FN_STL: begin
          ctrl.baseWs  = 1'b1;
          memReq       = 1'b1;
          memWe        = 1'b1;
          ctrl.stackOp = STK_POP1;
        end
        FN_STNL: begin
          memReq       = 1'b1;
          memWe        = 1'b1;
          ctrl.stackOp = STK_POP2;
        end
        FN_OPR: trapValid = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_exec_dp.sv
module stack_exec_dp
  import stack_exec_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_IP = '0,
  parameter logic [DATA_W-1:0] RESET_WP = DATA_W'(32'h80)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              aIsZero,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic [DATA_W-1:0] iptr,
  output logic [DATA_W-1:0] wptr
);

  localparam int unsigned WORD_SHIFT = $clog2(DATA_W / 8);

  logic [DATA_W-1:0] wordOffset;
  logic [DATA_W-1:0] effAddr;
  logic [DATA_W-1:0] ipNext;
  logic [DATA_W-1:0] newA;

  assign wordOffset = operand << WORD_SHIFT;
  assign effAddr    = (ctrl.baseWs ? wptr : regA) + wordOffset;
  assign ipNext     = iptr + DATA_W'(1);
  assign aIsZero    = (regA == '0);
  assign memAddr    = effAddr;
  assign memWdata   = ctrl.baseWs ? regA : regB;

  always_comb begin
    unique case (ctrl.aSel)
      ASEL_IMM:  newA = operand;
      ASEL_ADDR: newA = effAddr;
      ASEL_SUM:  newA = regA + operand;
      ASEL_EQ:   newA = (regA == operand) ? DATA_W'(1) : '0;
      ASEL_MEM:  newA = memRdata;
      ASEL_RET:  newA = ipNext;
      default:   newA = regA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
      regC <= '0;
    end else begin
      unique case (ctrl.stackOp)
        STK_PUSH: begin
          regC <= regB;
          regB <= regA;
          regA <= newA;
        end
        STK_POP1: begin
          regA <= regB;
          regB <= regC;
        end
        STK_POP2: begin
          regA <= regC;
          regB <= regC;
        end
        STK_REPLACE: regA <= newA;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iptr <= RESET_IP;
      wptr <= RESET_WP;
    end else begin
      unique case (ctrl.ipSel)
        IP_STEP:   iptr <= ipNext;
        IP_BRANCH: iptr <= ipNext + operand;
        default:   ;
      endcase
      if (ctrl.wpAdjust) wptr <= wptr + wordOffset;
    end
  end

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stack_exec_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_IP = '0,
  parameter logic [DATA_W-1:0] RESET_WP = DATA_W'(32'h80)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [3:0]        instFunc,
  input  logic [DATA_W-1:0] instOperand,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              trapValid,
  output logic [DATA_W-1:0] trapIndex,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic [DATA_W-1:0] iptr,
  output logic [DATA_W-1:0] wptr
);

  dpCtrl_t ctrl;
  logic    aIsZero;

  assign trapIndex = instOperand;

  stack_exec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instFunc  (funcCode_e'(instFunc)),
    .aIsZero   (aIsZero),
    .instReady (instReady),
    .memReq    (memReq),
    .memWe     (memWe),
    .trapValid (trapValid),
    .ctrl      (ctrl)
  );

  stack_exec_dp #(
    .DATA_W   (DATA_W),
    .RESET_IP (RESET_IP),
    .RESET_WP (RESET_WP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .operand  (instOperand),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .aIsZero  (aIsZero),
    .regA     (regA),
    .regB     (regB),
    .regC     (regC),
    .iptr     (iptr),
    .wptr     (wptr)
  );

endmodule

// File: rtl/stack_exec_chk.sv
module stack_exec_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic              instReady,
  input logic [3:0]        instFunc,
  input logic [DATA_W-1:0] instOperand,
  input logic              memReq,
  input logic              trapValid,
  input logic [DATA_W-1:0] trapIndex,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regB,
  input logic [DATA_W-1:0] regC,
  input logic [DATA_W-1:0] iptr,
  input logic [DATA_W-1:0] wptr
);

  logic fire;
  assign fire = instValid && instReady;

  // R2
  push_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && instFunc == 4'h4) |=>
      (regA == $past(instOperand) && regB == $past(regA) && regC == $past(regB)));

  // R4
  jump_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && instFunc == 4'h0) |=>
      (iptr == $past(iptr) + DATA_W'(1) + $past(instOperand)));

  // R9
  ptr_nomem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (instFunc == 4'h1 || instFunc == 4'h5)) |-> !memReq);

  // R10
  wp_adjust_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && instFunc == 4'hB) |=>
      (wptr == $past(wptr) + ($past(instOperand) << 2)));

  // R11
  load_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (instFunc == 4'h3 || instFunc == 4'h7)) |=> !instReady);

  // R11
  stall_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instReady |=> instReady);

  // R12
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> (fire && trapIndex == instOperand));

endmodule

bind stack_exec_unit stack_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .instValid   (instValid),
  .instReady   (instReady),
  .instFunc    (instFunc),
  .instOperand (instOperand),
  .memReq      (memReq),
  .trapValid   (trapValid),
  .trapIndex   (trapIndex),
  .regA        (regA),
  .regB        (regB),
  .regC        (regC),
  .iptr        (iptr),
  .wptr        (wptr)
);

// File: tb/stack_exec_unit_bench.sv
module stack_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic        instReady;
  logic [3:0]  instFunc = 4'h2;
  logic [31:0] instOperand = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        trapValid;
  logic [31:0] trapIndex;
  logic [31:0] regA, regB, regC, iptr, wptr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mem [64];

  logic        seenMemReq, seenTrap, readyAfter, trapAfter;
  logic [31:0] seenTrapIdx;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) mem[memAddr[7:2]] <= memWdata;
      else       memRdata <= mem[memAddr[7:2]];
    end
  end

  stack_exec_unit u_stack_exec_unit (
    .clk (clk), .rstN (rstN), .instValid (instValid), .instReady (instReady),
    .instFunc (instFunc), .instOperand (instOperand), .memReq (memReq),
    .memWe (memWe), .memAddr (memAddr), .memWdata (memWdata),
    .memRdata (memRdata), .trapValid (trapValid), .trapIndex (trapIndex),
    .regA (regA), .regB (regB), .regC (regC), .iptr (iptr), .wptr (wptr)
  );

  typedef struct packed {
    logic [3:0]  fn;
    logic [31:0] op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] ip;
    logic [31:0] wp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{4'h4, 32'd5,        32'd5,      32'd0,      32'd0,    32'h01, 32'h80, 8'd2},  // R2
    '{4'h4, 32'd7,        32'd7,      32'd5,      32'd0,    32'h02, 32'h80, 8'd2},  // R2
    '{4'h8, 32'hFFFFFFFD, 32'd4,      32'd5,      32'd0,    32'h03, 32'h80, 8'd3},  // R3
    '{4'hD, 32'd2,        32'd5,      32'd0,      32'd0,    32'h04, 32'h80, 8'd7},  // R7
    '{4'h7, 32'd2,        32'd4,      32'd5,      32'd0,    32'h05, 32'h80, 8'd7},  // R7
    '{4'hC, 32'd4,        32'd1,      32'd5,      32'd0,    32'h06, 32'h80, 8'd3},  // R3
    '{4'hC, 32'd0,        32'd0,      32'd5,      32'd0,    32'h07, 32'h80, 8'd3},  // R3
    '{4'hA, 32'd10,       32'd0,      32'd5,      32'd0,    32'h12, 32'h80, 8'd5},  // R5
    '{4'h4, 32'd9,        32'd9,      32'd0,      32'd5,    32'h13, 32'h80, 8'd2},  // R2
    '{4'hA, 32'd3,        32'd0,      32'd5,      32'd5,    32'h14, 32'h80, 8'd5},  // R5
    '{4'h1, 32'd1,        32'h84,     32'd0,      32'd5,    32'h15, 32'h80, 8'd9},  // R9
    '{4'h4, 32'h1234,     32'h1234,   32'h84,     32'd0,    32'h16, 32'h80, 8'd2},  // R2
    '{4'h4, 32'h90,       32'h90,     32'h1234,   32'h84,   32'h17, 32'h80, 8'd2},  // R2
    '{4'hE, 32'd1,        32'h84,     32'h84,     32'h84,   32'h18, 32'h80, 8'd8},  // R8
    '{4'h5, 32'd4,        32'h94,     32'h84,     32'h84,   32'h19, 32'h80, 8'd9},  // R9
    '{4'h3, 32'd0,        32'h1234,   32'h84,     32'h84,   32'h1A, 32'h80, 8'd8},  // R8
    '{4'hB, 32'hFFFFFFFE, 32'h1234,   32'h84,     32'h84,   32'h1B, 32'h78, 8'd10}, // R10
    '{4'h0, 32'hFFFFFFFB, 32'h1234,   32'h84,     32'h84,   32'h17, 32'h78, 8'd4},  // R4
    '{4'h9, 32'h20,       32'h18,     32'h1234,   32'h84,   32'h38, 32'h78, 8'd6},  // R6
    '{4'h2, 32'd3,        32'h18,     32'h1234,   32'h84,   32'h39, 32'h78, 8'd4},  // R4
    '{4'hF, 32'h21,       32'h18,     32'h1234,   32'h84,   32'h3A, 32'h78, 8'd12}, // R12
    '{4'h6, 32'd1,        32'h18,     32'h1234,   32'h84,   32'h3B, 32'h78, 8'd4}   // R4
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One instruction, then one idle cycle so that a load completes.
  task automatic issue(input logic [3:0] fn, input logic [31:0] op);
    @(negedge clk);
    instValid   = 1'b1;
    instFunc    = fn;
    instOperand = op;
    #1;
    seenMemReq  = memReq;
    seenTrap    = trapValid;
    seenTrapIdx = trapIndex;
    @(negedge clk);
    instValid = 1'b0;
    instFunc  = 4'h2;
    #1;
    readyAfter = instReady;
    trapAfter  = trapValid;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "A", regA, 32'd0);
    check("R1", "B", regB, 32'd0);
    check("R1", "C", regC, 32'd0);
    check("R1", "ip", iptr, 32'd0);
    check("R1", "wp", wptr, 32'h80);
    check("R1", "ready", {31'd0, instReady}, 32'd1);
    check("R1", "memReq", {31'd0, memReq}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      issue(VECS[i].fn, VECS[i].op);
      tag = $sformatf("R%0d step %0d", VECS[i].req, i);
      check(tag, "A", regA, VECS[i].a);
      check(tag, "B", regB, VECS[i].b);
      check(tag, "C", regC, VECS[i].c);
      check(tag, "ip", iptr, VECS[i].ip);
      check(tag, "wp", wptr, VECS[i].wp);
      if (VECS[i].fn == 4'h1 || VECS[i].fn == 4'h5)
        check("R9", "pointer load memReq", {31'd0, seenMemReq}, 32'd0);
      if (VECS[i].fn == 4'hF) begin
        check("R12", "trap at accept", {31'd0, seenTrap}, 32'd1);
        check("R12", "trap index", seenTrapIdx, 32'h21);
        check("R12", "trap next cycle", {31'd0, trapAfter}, 32'd0);
      end
    end

    // R7 and R8 memory contents written by the two store forms
    check("R7", "stl word", mem[6'h22], 32'd4);
    check("R8", "stnl word", mem[6'h25], 32'h1234);

    // R11 ready drops for one cycle during a load; wp 0x78 + 16 = 0x88
    issue(4'h7, 32'd4);
    check("R11", "ready in wait cycle", {31'd0, readyAfter}, 32'd0);
    check("R11", "ready after load", {31'd0, instReady}, 32'd1);
    check("R11", "loaded A", regA, 32'd4);
    check("R11", "pushed B", regB, 32'h18);

    // R12 trap leaves stack and workspace alone
    issue(4'hF, 32'h2A);
    check("R12", "trap index", seenTrapIdx, 32'h2A);
    check("R12", "A unchanged", regA, 32'd4);
    check("R12", "wp unchanged", wptr, 32'h78);

    // R1 reset from a busy state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "A after reset", regA, 32'd0);
    check("R1", "ip after reset", iptr, 32'd0);
    check("R1", "wp after reset", wptr, 32'h80);
    rstN = 1'b1;

    done = 1'b1;
    summary();
  end

endmodule